// File: doc/BRIEF.md
# Masked Alias Counter Register Unit

This unit keeps two 64-bit event counters for a 32-bit core: one counts clock ticks and the other counts retired instructions. Each counter is reached through two register ports of 32 bits, a low half and a high half, at a fully writable machine-level address pair. Each counter is also reached through a user-level alias pair that does not store anything of its own. An alias is a filtered window onto the machine register. A read returns the register half ANDed with the alias read mask. A write is merged into the register half under the alias write mask.

The defaults make the user aliases read-only: the read mask is all ones and the write mask is all zeros. A zero write mask drops every write, set and clear made through that alias. The masks are parameters, set for each counter, so an integrator can open or narrow a view. Accesses use one request strobe with an address, an operation code and write data. The unit never applies back-pressure: it accepts a request in every cycle in which the strobe is high. Exactly one cycle later it presents one response, carrying the read data and an illegal-address flag. The response has no ready input, so the consumer must take it in that cycle.

Top module: `csr_ctr_unit`

## Requirements
- R1: Synchronous reset clears both 64-bit counters and drops `rsp_valid`.
- R2: The cycle counter adds one on each clock where `tick` is high. The retire counter adds one on each clock where `retire` is high.
- R3: A carry out of a low half propagates into the high half. Address bit 7 selects the half (0 low, 1 high), and address bit 1 selects the counter (0 cycle, 1 retire).
- R4: The machine addresses 0xB00, 0xB80, 0xB02 and 0xB82 accept three operation codes. Code 0 writes the data. Code 1 ORs the data into the half. Code 2 clears the bits that are set in the data. All 32 bits of the half are affected. Code 3 only reads.
- R5: When a request updates any half of a counter, that counter skips its increment in the same cycle.
- R6: Reads at 0xC00/0xC80 (cycle) and 0xC02/0xC82 (retire) return the addressed half ANDed with that counter's user read mask.
- R7: If a user alias has a write mask of zero, its write, set and clear operations leave the counter unchanged.
- R8: Any other address, including 0xC01 and 0xC81, gives `rsp_illegal`=1 and `rsp_rdata`=0, and changes no state.
- R9: Each accepted request gives exactly one response in the next cycle. Its read data is the value the register held before that request's own update.
- R10: With a nonzero user write mask, an alias operation first forms a candidate value. For a write this is the data. For a set it is the unmasked half ORed with the data. For a clear it is the unmasked half with the data bits cleared. The half then becomes (half AND NOT mask) OR (candidate AND mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Cycle-count enable |
| retire | input | 1 | Instruction-retired pulse |
| req_valid | input | 1 | Request strobe; always accepted |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 read only |
| req_wdata | input | XLEN | Operand data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | XLEN | Masked pre-update read value |
| rsp_illegal | output | 1 | Address not implemented |

## Verification
A corrupted counter bit is invisible until a read targets that half. It then appears in the response one cycle after the request and stays wrong in every later read, because increments build on it. An increment that was lost or doubled, or a carry that went astray, therefore shows as a fixed offset in the next read of the low or high half. A mask or merge fault only shows after an alias operation, so the bench follows every such operation with a read of the unmasked machine address. A wrong half select or counter select corrupts the register that is not being accessed, so the bench reads both counters back after each group of operations.

// File: rtl/csr_ctr_pkg.sv
package csr_ctr_pkg;
  localparam int ADDR_W  = 12;
  localparam int NUM_CTR = 2;
  localparam int SEL_W   = $clog2(NUM_CTR);
  // address fields the decoder depends on
  localparam int HALF_BIT = 7;
  localparam int CTR_BIT  = 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } csr_op_e;

  typedef enum logic [SEL_W-1:0] {
    CTR_CYC = 1'b0,
    CTR_RET = 1'b1
  } ctr_sel_e;

  typedef struct packed {
    logic     hit;
    ctr_sel_e ctr;
    logic     hi;
  } csr_dec_t;
endpackage

// File: rtl/csr_ctr_dec.sv
module csr_ctr_dec
  import csr_ctr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] CYC_RMASK = '1,
  parameter logic [XLEN-1:0] CYC_WMASK = '0,
  parameter logic [XLEN-1:0] RET_RMASK = '1,
  parameter logic [XLEN-1:0] RET_WMASK = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_dec_t          dec,
  output logic [XLEN-1:0]   rmask,
  output logic [XLEN-1:0]   wmask
);
  logic is_mach, is_user, slot_ok;

  always_comb begin
    is_mach = (addr[11:8] == 4'hB);
    is_user = (addr[11:8] == 4'hC);
    slot_ok = (addr[6:0] == 7'd0) || (addr[6:0] == 7'd2);
    dec.hit = (is_mach || is_user) && slot_ok;
    dec.ctr = ctr_sel_e'(addr[CTR_BIT]);
    dec.hi  = addr[HALF_BIT];
    rmask   = '0;
    wmask   = '0;
    if (dec.hit) begin
      if (is_mach) begin
        rmask = '1;
        wmask = '1;
      end else if (dec.ctr == CTR_CYC) begin
        rmask = CYC_RMASK;
        wmask = CYC_WMASK;
      end else begin
        rmask = RET_RMASK;
        wmask = RET_WMASK;
      end
    end
  end
endmodule

// File: rtl/csr_ctr_merge.sv
module csr_ctr_merge
  import csr_ctr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            act,
  input  csr_op_e         op,
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] wmask,
  output logic            we,
  output logic [XLEN-1:0] nxt
);
  logic [XLEN-1:0] cand;

  always_comb begin
    unique case (op)
      OP_WRITE: cand = wdata;
      OP_SET:   cand = cur | wdata;
      OP_CLEAR: cand = cur & ~wdata;
      default:  cand = cur;
    endcase
    nxt = (cur & ~wmask) | (cand & wmask);
    // a zero mask means the alias drops the access entirely
    we  = act && (op != OP_READ) && (|wmask);
  end
endmodule

// File: rtl/csr_ctr_cnt.sv
module csr_ctr_cnt #(
  parameter int XLEN = 32,
  localparam int CNT_W = 2 * XLEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo || wr_hi) begin
      // software update wins over the increment of this cycle
      if (wr_lo) cnt[XLEN-1:0]     <= wdata;
      if (wr_hi) cnt[CNT_W-1:XLEN] <= wdata;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/csr_ctr_unit.sv
module csr_ctr_unit
  import csr_ctr_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] CYC_RMASK = '1,
  parameter logic [XLEN-1:0] CYC_WMASK = '0,
  parameter logic [XLEN-1:0] RET_RMASK = '1,
  parameter logic [XLEN-1:0] RET_WMASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              retire,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_illegal
);
  localparam int CNT_W = 2 * XLEN;

  csr_dec_t                      dec;
  logic [XLEN-1:0]               rmask, wmask, cur, nxt;
  logic                          we;
  logic [SEL_W-1:0]              sel_idx;
  logic [NUM_CTR-1:0]            inc_vec;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_all;
  logic [CNT_W-1:0]              cyc_cnt, ret_cnt;

  csr_ctr_dec #(
    .XLEN(XLEN), .CYC_RMASK(CYC_RMASK), .CYC_WMASK(CYC_WMASK),
    .RET_RMASK(RET_RMASK), .RET_WMASK(RET_WMASK)
  ) u_dec (
    .addr(req_addr), .dec(dec), .rmask(rmask), .wmask(wmask)
  );

  assign sel_idx = SEL_W'(dec.ctr);
  assign inc_vec = {retire, tick};

  always_comb begin
    if (dec.hi) cur = cnt_all[sel_idx][CNT_W-1:XLEN];
    else        cur = cnt_all[sel_idx][XLEN-1:0];
  end

  csr_ctr_merge #(.XLEN(XLEN)) u_merge (
    .act(req_valid && dec.hit), .op(csr_op_e'(req_op)), .cur(cur),
    .wdata(req_wdata), .wmask(wmask), .we(we), .nxt(nxt)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic mine;
    assign mine = we && (sel_idx == SEL_W'(g));
    csr_ctr_cnt #(.XLEN(XLEN)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc_vec[g]),
      .wr_lo(mine && !dec.hi), .wr_hi(mine && dec.hi),
      .wdata(nxt), .cnt(cnt_all[g])
    );
  end

  assign cyc_cnt = cnt_all[0];
  assign ret_cnt = cnt_all[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && !dec.hit;
      rsp_rdata   <= (req_valid && dec.hit) ? (cur & rmask) : '0;
    end
  end
endmodule

// File: rtl/csr_ctr_unit_chk.sv
module csr_ctr_unit_chk #(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RET_WMASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              retire,
  input logic              req_valid,
  input logic [11:0]       req_addr,
  input logic              rsp_valid,
  input logic [XLEN-1:0]   rsp_rdata,
  input logic              rsp_illegal,
  input logic [2*XLEN-1:0] cyc_cnt,
  input logic [2*XLEN-1:0] ret_cnt
);
  logic ret_alias_hit;
  assign ret_alias_hit = req_valid && (req_addr[11:8] == 4'hC) &&
                         (req_addr[6:0] == 7'd2) && (RET_WMASK == '0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cyc_cnt == '0) && (ret_cnt == '0) && !rsp_valid);

  p_cycle_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && tick) |=> cyc_cnt == $past(cyc_cnt) + 1'b1);

  p_retire_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && retire) |=> ret_cnt == $past(ret_cnt) + 1'b1);

  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && tick && (cyc_cnt[XLEN-1:0] == '1)) |=>
      cyc_cnt[2*XLEN-1:XLEN] == $past(cyc_cnt[2*XLEN-1:XLEN]) + 1'b1);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !tick) |=> $stable(cyc_cnt));

  p_alias_ro_r7: assert property (@(posedge clk) disable iff (rst)
    (ret_alias_hit && !retire) |=> $stable(ret_cnt));

  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_valid && (rsp_rdata == '0)));

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_extra_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind csr_ctr_unit csr_ctr_unit_chk #(.XLEN(XLEN), .RET_WMASK(RET_WMASK)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .retire(retire),
  .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
  .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt)
);

// File: tb/csr_ctr_unit_tb_top.sv
module csr_ctr_unit_tb_top;
  localparam logic [31:0] CR = 32'hFFFF_00FF;
  localparam logic [31:0] CW = 32'h0000_FFF0;
  localparam logic [31:0] RR = 32'hFFFF_FFFF;
  localparam logic [31:0] RW = 32'h0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, retire = 1'b0, req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_illegal;
  logic [31:0] rsp_rdata;

  always #5 clk = ~clk;

  csr_ctr_unit #(.XLEN(32), .CYC_RMASK(CR), .CYC_WMASK(CW),
                 .RET_RMASK(RR), .RET_WMASK(RW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .retire(retire),
    .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal)
  );

  typedef struct {
    logic [31:0] d;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] m_cnt [2];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; model predicts the response and the new state
  task automatic drv(input bit v, input logic [11:0] a, input logic [1:0] op,
                     input logic [31:0] d, input bit tk, input bit rt, input string tag);
    bit hit, usr, hi;
    int c;
    logic [31:0] rm, wm, cur, cand, nv;
    bit [1:0] wrote;
    exp_t e;
    hit = ((a[11:8] == 4'hB) || (a[11:8] == 4'hC)) && ((a[6:0] == 7'd0) || (a[6:0] == 7'd2));
    usr = (a[11:8] == 4'hC);
    c   = int'(a[1]);
    hi  = a[7];
    rm  = !hit ? 32'h0 : !usr ? 32'hFFFF_FFFF : (c == 0) ? CR : RR;
    wm  = !hit ? 32'h0 : !usr ? 32'hFFFF_FFFF : (c == 0) ? CW : RW;
    cur = hi ? m_cnt[c][63:32] : m_cnt[c][31:0];
    if (v) begin
      e.d = hit ? (cur & rm) : 32'h0;
      e.ill = !hit;
      e.tag = tag;
      q.push_back(e);
    end
    wrote = 2'b00;
    if (v && hit && op != 2'd3 && wm != 32'h0) begin
      case (op)
        2'd0: cand = d;
        2'd1: cand = cur | d;
        default: cand = cur & ~d;
      endcase
      nv = (cur & ~wm) | (cand & wm);
      if (hi) m_cnt[c][63:32] = nv; else m_cnt[c][31:0] = nv;
      wrote[c] = 1'b1;
    end
    if (tk && !wrote[0]) m_cnt[0] = m_cnt[0] + 64'd1;
    if (rt && !wrote[1]) m_cnt[1] = m_cnt[1] + 64'd1;
    req_valid = v; req_addr = a; req_op = op; req_wdata = d; tick = tk; retire = rt;
    @(negedge clk);
    req_valid = 1'b0; tick = 1'b0; retire = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    drv(1, a, 2'd3, 32'h0, 0, 0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 12'h0, 2'd3, 32'h0, 0, 0, "idle");
  endtask

  // monitor: pops the scoreboard as responses arrive
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && rsp_valid) begin
        if (q.size() == 0) begin
          check("R9 unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " data"}, {32'h0, rsp_rdata}, {32'h0, e.d});
          check({e.tag, " illegal"}, {63'h0, rsp_illegal}, {63'h0, e.ill});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_cnt[0] = 64'h0; m_cnt[1] = 64'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    @(negedge clk);
    // R1: all halves zero
    rd(12'hB00, "R1"); rd(12'hB80, "R1"); rd(12'hB02, "R1"); rd(12'hB82, "R1");
    // R2: counting
    for (int i = 0; i < 5; i++) drv(0, 12'h0, 2'd3, 0, 1, (i < 3), "R2");
    rd(12'hB00, "R2"); rd(12'hB02, "R2");
    // R3: carry into high half
    drv(1, 12'hB00, 2'd0, 32'hFFFF_FFFE, 0, 0, "R4");
    for (int i = 0; i < 3; i++) drv(0, 12'h0, 2'd3, 0, 1, 0, "R3");
    rd(12'hB00, "R3"); rd(12'hB80, "R3");
    // R4: set / clear on retire high half
    drv(1, 12'hB82, 2'd1, 32'h0000_00F0, 0, 0, "R4");
    drv(1, 12'hB82, 2'd2, 32'h0000_0030, 0, 0, "R4");
    rd(12'hB82, "R4"); rd(12'hB02, "R4");
    // R5: write beats same-cycle increment
    drv(1, 12'hB00, 2'd0, 32'h0000_0100, 1, 0, "R5");
    drv(1, 12'hB82, 2'd0, 32'h0000_0007, 0, 1, "R5");
    rd(12'hB00, "R5"); rd(12'hB82, "R5"); rd(12'hB02, "R5");
    // R6: alias reads through masks
    drv(1, 12'hB00, 2'd0, 32'h1234_5678, 0, 0, "R6");
    rd(12'hC00, "R6"); rd(12'hC80, "R6"); rd(12'hC02, "R6"); rd(12'hC82, "R6");
    // R7: zero-mask alias drops all updates
    drv(1, 12'hC02, 2'd0, 32'hDEAD_BEEF, 0, 0, "R7");
    drv(1, 12'hC82, 2'd1, 32'hFFFF_FFFF, 0, 0, "R7");
    drv(1, 12'hC02, 2'd2, 32'hFFFF_FFFF, 0, 0, "R7");
    rd(12'hB02, "R7"); rd(12'hB82, "R7");
    // R10: masked merge through the cycle alias
    drv(1, 12'hC00, 2'd0, 32'hAAAA_AAAA, 0, 0, "R10");
    rd(12'hB00, "R10");
    drv(1, 12'hC80, 2'd1, 32'h0000_0F0F, 0, 0, "R10");
    rd(12'hB80, "R10");
    drv(1, 12'hC00, 2'd2, 32'hFFFF_FFFF, 0, 0, "R10");
    rd(12'hB00, "R10"); rd(12'hC00, "R10");
    // R8: illegal addresses
    drv(1, 12'hC01, 2'd0, 32'hFFFF_FFFF, 0, 0, "R8");
    drv(1, 12'hC81, 2'd3, 32'h0, 0, 0, "R8");
    drv(1, 12'hB01, 2'd1, 32'hFFFF_FFFF, 0, 0, "R8");
    drv(1, 12'h300, 2'd0, 32'h5555_5555, 0, 0, "R8");
    rd(12'hB00, "R8"); rd(12'hB80, "R8"); rd(12'hB02, "R8"); rd(12'hB82, "R8");
    // R9: back-to-back, response carries the pre-update value
    drv(1, 12'hB02, 2'd0, 32'h0000_00AA, 0, 0, "R9");
    drv(1, 12'hB02, 2'd1, 32'h0000_0F00, 0, 1, "R9");
    drv(1, 12'hB02, 2'd3, 32'h0, 0, 1, "R9");
    rd(12'hB02, "R9");
    idle(3);
    check("R9 all responses seen", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule